// File: doc/BRIEF.md
# Counter-Compare PWM Channel

This block produces one pulse-width-modulated pin from a free-running timebase that lives outside it. The timebase arrives as a count value plus a one-cycle overflow strobe. The strobe is high in the same clock in which the count shows zero after wrapping. The channel holds a compare value and a registered set/reset output. The output is set when the count equals the compare value and cleared when the timebase overflows. The fraction of the period spent high is therefore (2^W − compare) / 2^W, where W is the compare width.

Software reaches the channel through a plain synchronous register bus that is 8 bits wide. It has a 2-bit address for control, compare-low and compare-high. The compare value is written in two halves. A low-half write disarms compare matching and a high-half write re-arms it, so a half-updated value can never produce a match. Leaving the channel disarmed gives 0% duty. Every match sets a sticky flag. An interrupt request can be raised from that flag so software can reload the compare value in step with the waveform. The bus has no back-pressure: a write is taken on every clock in which `wr_en` is high, and readback is combinational. There is no stream interface.

Register map: address 0 is control, with bit0 arm (compare enable), bit1 PWM enable, bit2 wide-mode select, bit3 match-interrupt enable, bit4 flag-interrupt enable and bit7 the match flag. Address 1 holds the low half of the compare value and address 2 the high half. Address 3 reads as 0.

Top module: `pwm16_channel`

## Requirements
- R1: After synchronous reset the pin and `irq` are low, and every readback address returns 0.
- R2: With arm, PWM enable and wide select all 1, a clock in which `tb_count` equals the compare value makes `pwm_out` high from the next clock.
- R3: A clock with `tb_ovf` high and no match makes `pwm_out` low from the next clock.
- R4: When a match and an overflow fall in the same clock, the set wins, so a compare value of 0 keeps `pwm_out` high for the whole period.
- R5: A write to address 1 clears the arm bit (control bit0) and a write to address 2 sets it; both halves read back as written.
- R6: While any of the arm, PWM enable (bit1) or wide select (bit2) bits is 0, no match occurs and `pwm_out` never rises.
- R7: Over one full timebase period starting at an overflow, `pwm_out` is high for exactly 2^W − C clocks, where C is the compare value.
- R8: A match sets the flag (control bit7). It stays set until a control write with bit7 = 0, and a control write with bit7 = 1 leaves it unchanged.
- R9: `irq` is high exactly when the flag, the match-interrupt enable (bit3) and the flag-interrupt enable (bit4) are all 1.
- R10: The control readback returns bits 4:0 as last written, apart from arm changes caused by compare writes, with the flag in bit7 and 0 in bits 6:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tb_count | input | CMP_W | Current timebase count |
| tb_ovf | input | 1 | Timebase overflow strobe, high in the clock the count shows zero after wrapping |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Readback address |
| rd_data | output | 8 | Readback data, combinational |
| pwm_out | output | 1 | PWM pin |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check several things. They check that a match sets the output and the flag, that an overflow without a match clears the output, and that a coincident match wins. They check that the output never rises without a match. They check that the two compare-half writes drive the arm bit, and that the flag holds until a clearing write. The duty cycle as a count over a full period cannot be shown by a single-cycle property. The bench measures it by sweeping every compare value of an 8-bit configuration. Register readback and the interrupt gating under different enable patterns are also shown only by the bench's scenarios.

// File: rtl/pwm16_pkg.sv
package pwm16_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CMPL = 2'd1;
  localparam logic [1:0] ADDR_CMPH = 2'd2;

  localparam int CB_FLAG = 7;

  typedef struct packed {
    logic flag_ie;
    logic match_ie;
    logic wide_sel;
    logic pwm_en;
    logic cmp_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pwm16_regs.sv
module pwm16_regs
  import pwm16_pkg::*;
#(
  parameter int CMP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output ctrl_t            ctrl,
  output logic [CMP_W-1:0] cmp_val,
  output logic             flag_clr
);
  localparam int HALF_W = CMP_W / 2;

  ctrl_t            ctrl_q;
  logic [CMP_W-1:0] cmp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL: ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
        ADDR_CMPL: begin
          cmp_q[HALF_W-1:0] <= wr_data[HALF_W-1:0];
          ctrl_q.cmp_en     <= 1'b0;
        end
        ADDR_CMPH: begin
          cmp_q[CMP_W-1:HALF_W] <= wr_data[HALF_W-1:0];
          ctrl_q.cmp_en         <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign ctrl     = ctrl_q;
  assign cmp_val  = cmp_q;
  assign flag_clr = wr_en && (wr_addr == ADDR_CTRL) && !wr_data[CB_FLAG];
endmodule

// File: rtl/pwm16_match.sv
module pwm16_match
  import pwm16_pkg::*;
#(
  parameter int CMP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  input  logic [CMP_W-1:0] cmp_val,
  input  logic [CMP_W-1:0] tb_count,
  input  logic             tb_ovf,
  input  logic             flag_clr,
  output logic             hit,
  output logic             flag,
  output logic             pwm_out
);
  logic armed;
  logic flag_q;
  logic out_q;

  assign armed = ctrl.cmp_en && ctrl.pwm_en && ctrl.wide_sel;
  assign hit   = armed && (tb_count == cmp_val);

  // Output latch: set has priority over the overflow reset.
  always_ff @(posedge clk) begin
    if (rst)         out_q <= 1'b0;
    else if (hit)    out_q <= 1'b1;
    else if (tb_ovf) out_q <= 1'b0;
  end

  // Sticky flag: a new match beats a clearing write in the same clock.
  always_ff @(posedge clk) begin
    if (rst)           flag_q <= 1'b0;
    else if (hit)      flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign flag    = flag_q;
  assign pwm_out = out_q;
endmodule

// File: rtl/pwm16_channel.sv
module pwm16_channel
  import pwm16_pkg::*;
#(
  parameter int CMP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CMP_W-1:0] tb_count,
  input  logic             tb_ovf,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [1:0]       rd_addr,
  output logic [7:0]       rd_data,
  output logic             pwm_out,
  output logic             irq
);
  localparam int HALF_W = CMP_W / 2;

  ctrl_t            ctrl_q;
  logic [CMP_W-1:0] cmp_val;
  logic             flag_clr;
  logic             hit;
  logic             flag;

  pwm16_regs #(.CMP_W(CMP_W)) regs_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ctrl     (ctrl_q),
    .cmp_val  (cmp_val),
    .flag_clr (flag_clr)
  );

  pwm16_match #(.CMP_W(CMP_W)) match_i (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl_q),
    .cmp_val  (cmp_val),
    .tb_count (tb_count),
    .tb_ovf   (tb_ovf),
    .flag_clr (flag_clr),
    .hit      (hit),
    .flag     (flag),
    .pwm_out  (pwm_out)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_CTRL: begin
        rd_data[CTRL_W-1:0] = ctrl_q;
        rd_data[CB_FLAG]    = flag;
      end
      ADDR_CMPL: rd_data[HALF_W-1:0] = cmp_val[HALF_W-1:0];
      ADDR_CMPH: rd_data[HALF_W-1:0] = cmp_val[CMP_W-1:HALF_W];
      default:   rd_data = '0;
    endcase
  end

  assign irq = flag && ctrl_q.match_ie && ctrl_q.flag_ie;
endmodule

// File: rtl/pwm16_checker.sv
module pwm16_checker
  import pwm16_pkg::*;
#(
  parameter int CMP_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CMP_W-1:0] tb_count,
  input logic             tb_ovf,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic             wr_flag_bit,
  input ctrl_t            ctrl,
  input logic [CMP_W-1:0] cmp_val,
  input logic             flag,
  input logic             pwm_out
);
  logic match_now;
  assign match_now = ctrl.cmp_en && ctrl.pwm_en && ctrl.wide_sel && (tb_count == cmp_val);

  AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    match_now |=> pwm_out);  // R2
  AST_CLR_ON_OVF: assert property (@(posedge clk) disable iff (rst)
    (tb_ovf && !match_now) |=> !pwm_out);  // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (tb_ovf && match_now) |=> pwm_out);  // R4
  AST_LOW_DISARMS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_CMPL) |=> !ctrl.cmp_en);  // R5
  AST_HIGH_ARMS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_CMPH) |=> ctrl.cmp_en);  // R5
  AST_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    (!pwm_out && !match_now) |=> !pwm_out);  // R6
  AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    match_now |=> flag);  // R8
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (flag && !(wr_en && wr_addr == ADDR_CTRL && !wr_flag_bit)) |=> flag);  // R8
endmodule

bind pwm16_channel pwm16_checker #(.CMP_W(CMP_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .tb_count    (tb_count),
  .tb_ovf      (tb_ovf),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_flag_bit (wr_data[pwm16_pkg::CB_FLAG]),
  .ctrl        (ctrl_q),
  .cmp_val     (cmp_val),
  .flag        (flag),
  .pwm_out     (pwm_out)
);

// File: tb/pwm16_channel_tb.sv
module pwm16_channel_tb_top;
  localparam int W      = 8;
  localparam int PERIOD = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] cnt = '0;
  logic         ovf;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [7:0]   wr_data = '0;
  logic [1:0]   rd_addr = '0;
  logic [7:0]   rd_data;
  logic         pwm_out;
  logic         irq;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  logic s [PERIOD];

  assign ovf = (cnt == '0);

  always #10 clk = ~clk;

  pwm16_channel #(.CMP_W(W)) dut_i (
    .clk(clk), .rst(rst), .tb_count(cnt), .tb_ovf(ovf),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out), .irq(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cnt   = cnt + 1'b1;
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic set_cmp(input int c);
    wr(2'd1, 8'(c % 16));
    wr(2'd2, 8'(c / 16));
  endtask

  task automatic run_period(output int highs);
    while (cnt != '0) tick();
    highs = 0;
    for (int i = 0; i < PERIOD; i++) begin
      tick();
      s[i] = pwm_out;
      if (pwm_out) highs++;
    end
  endtask

  initial begin
    logic [7:0] d;
    int h;
    @(negedge clk);
    repeat (3) tick();
    rst = 1'b0;

    // R1 reset state
    check(pwm_out == 1'b0, "R1 pwm_out", pwm_out, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check(d == 8'h00, "R1 readback", d, 0);
    end

    // R5 / R10 compare halves and arm bit
    wr(2'd0, 8'h06);
    rd(2'd0, d);
    check(d[4:0] == 5'h06, "R10 ctrl readback", d[4:0], 6);
    wr(2'd1, 8'h0A);
    rd(2'd0, d);
    check(d[0] == 1'b0, "R5 low write disarms", d[0], 0);
    rd(2'd1, d);
    check(d == 8'h0A, "R5 low half readback", d, 10);
    wr(2'd2, 8'h03);
    rd(2'd0, d);
    check(d[4:0] == 5'h07, "R5 high write arms", d[4:0], 7);
    check(d[6:5] == 2'b00, "R10 spare bits", d[6:5], 0);
    rd(2'd2, d);
    check(d == 8'h03, "R5 high half readback", d, 3);

    // R4 compare 0 steady high
    set_cmp(0);
    run_period(h);
    run_period(h);
    check(h == PERIOD, "R4 full-high count", h, PERIOD);
    check(s[0] == 1'b1, "R4 set wins at overflow", s[0], 1);

    // R6 disarmed: no rise
    wr(2'd0, 8'h06);
    run_period(h);
    check(h == 0, "R6 disarmed highs", h, 0);
    wr(2'd0, 8'h03);
    run_period(h);
    check(h == 0, "R6 wide off highs", h, 0);
    wr(2'd0, 8'h05);
    run_period(h);
    check(h == 0, "R6 pwm off highs", h, 0);

    // R2 / R3 edge timing with compare 0x10
    wr(2'd0, 8'h1E);
    set_cmp(16);
    run_period(h);
    run_period(h);
    check(s[15] == 1'b0, "R2 low before match", s[15], 0);
    check(s[16] == 1'b1, "R2 high after match", s[16], 1);
    check(s[PERIOD-1] == 1'b1, "R2 high at end", s[PERIOD-1], 1);
    check(s[0] == 1'b0, "R3 low after overflow", s[0], 0);

    // R8 / R9 flag and interrupt gating (arm cleared by control writes)
    wr(2'd0, 8'h9E);
    rd(2'd0, d);
    check(d[7] == 1'b1, "R8 flag set, write 1 keeps", d[7], 1);
    check(irq == 1'b1, "R9 irq all enables", irq, 1);
    wr(2'd0, 8'h8E);
    check(irq == 1'b0, "R9 irq flag-ie off", irq, 0);
    rd(2'd0, d);
    check(d[7] == 1'b1, "R8 flag still set", d[7], 1);
    wr(2'd0, 8'h96);
    check(irq == 1'b0, "R9 irq match-ie off", irq, 0);
    wr(2'd0, 8'h1E);
    rd(2'd0, d);
    check(d[7] == 1'b0, "R8 flag cleared", d[7], 0);
    check(irq == 1'b0, "R9 irq flag clear", irq, 0);

    // R7 duty sweep over every compare value
    wr(2'd0, 8'h06);
    for (int c = 0; c < PERIOD; c++) begin
      set_cmp(c);
      run_period(h);
      check(h == PERIOD - c, "R7 duty count", h, PERIOD - c);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule